// File: doc/BRIEF.md
# Interlaced Raster Timing and Interrupt Generator

This block produces the scan timing for a two-field interlaced frame of 625 lines, each line 128 clock cycles long. A single frame-cycle counter drives everything. From that counter the block derives a line index within the field, a column index within the line, a field flag, horizontal and vertical sync, and an output stage: sync, blank or pixels. At fixed counter positions it raises two kinds of one-cycle interrupt pulse: one when a field's display area ends, and one as a real-time-clock tick.

During the pixel stage the block reads bytes from screen memory through an address-out, data-in port. The memory answers within the same cycle. Each fetched byte appears as eight 1-bit pixels on a parallel pixel bus, leftmost pixel in bit 0. Wide mode fetches on every pixel-stage cycle, giving 640 pixels per line. Half-rate mode fetches only on pixel-stage cycles where bit 3 of the raw in-line cycle count is set, giving 320 pixels per line. Screen memory is read linearly from a fixed base address, restarting at the top of each field.

All registered outputs for frame cycle n become valid in the cycle in which the frame counter holds n. Reset forces the counter to cycle 0.

Top module: `raster_timing_gen`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, the outputs show frame cycle 0: line_o = 281, col_o = 95, field_o = 0, stage_o = 1 (blank), hsync_o = vsync_o = 0, and no interrupt pulse, fetch or pixel.
- R2: The frame counter advances by one each cycle. Frame cycle n lies on raw line n/128 at raw in-line cycle n mod 128. The counter wraps from 79999 to 0, so after 80000 cycles the outputs show cycle 0 again.
- R3: line_o = (raw line − 31) mod 312 and col_o = (raw in-line cycle − 33) mod 128. field_o is 1 exactly for raw lines 343 to 624.
- R4: With default parameters, hsync_o is 1 for raw in-line cycles 8 to 17. vsync_o is 1 for raw lines 4 to 6 and 316 to 318.
- R5: stage_o is 0 (sync) when hsync_o or vsync_o is set. Otherwise it is 2 (pixels) when line_o < 256 and col_o < 80. Otherwise it is 1 (blank). The value 3 never appears.
- R6: irq_disp_end_o is a one-cycle pulse, high exactly at frame cycles 36736 and 76672.
- R7: irq_rtc_o is a one-cycle pulse, high exactly at frame cycles 16704 and 56704, including the first frame after a reset taken mid-frame.
- R8: In wide mode (mode_half_i = 0) every pixel-stage cycle fetches one byte, which gives 163840 pixels per field.
- R9: In half-rate mode (mode_half_i = 1) a pixel-stage cycle fetches only when bit 3 of the raw in-line cycle is 1, which gives 81920 pixels per field.
- R10: In a fetch cycle, pix_o[i] equals bit (7 − i) of mem_data_i: the most significant bit is the leftmost pixel, a set bit is lit (1) and a clear bit is dark (0). When pix_vld_o is 0, pix_o is all zero.
- R11: mem_rd_o and pix_vld_o are high exactly in fetch cycles. The first fetch of each field reads address 0x3000, and each later fetch in the field reads the previous fetch address plus one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| mode_half_i | input | 1 | 1 selects half-rate fetching, 0 selects wide |
| mem_data_i | input | 8 | Byte returned by screen memory in the same cycle |
| mem_rd_o | output | 1 | Screen memory read in this cycle |
| mem_addr_o | output | 16 | Screen memory byte address |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| stage_o | output | 2 | 0 sync, 1 blank, 2 pixels |
| field_o | output | 1 | 1 during the second field |
| line_o | output | 10 | Line index relative to the first display line, modulo 312 |
| col_o | output | 7 | Column relative to the first display cycle, modulo 128 |
| irq_disp_end_o | output | 1 | Display-end interrupt pulse |
| irq_rtc_o | output | 1 | Real-time-clock interrupt pulse |
| pix_vld_o | output | 1 | pix_o carries a fetched byte |
| pix_o | output | 8 | Eight pixels, bit 0 leftmost |

## Verification
The properties assume that reset is held for at least two clock edges. Over that time the history terms see defined values, and the column-step property skips the first edge after release. They also assume that mode_half_i changes only while no fetch is under way, so that address steps between consecutive fetches stay within one line. The stimulus holds reset for three edges. It changes the mode only at frame cycle 0, which lies outside the display area. The memory model is a pure function of the address, so every fetched byte can be predicted from the expected address sequence.

// File: rtl/rtg_pkg.sv
package rtg_pkg;

    // Output stage codes seen on stage_o.
    typedef enum logic [1:0] {
        STG_SYNC  = 2'd0,
        STG_BLANK = 2'd1,
        STG_PIXEL = 2'd2
    } stage_e;

endpackage

// File: rtl/rtg_frame_ctr.sv
module rtg_frame_ctr #(
    parameter int unsigned FRAME_CYC = 80000,
    parameter int unsigned CNT_W     = 17
) (
    input  logic             clk_i,
    input  logic             rst_i,
    output logic [CNT_W-1:0] pos_q_o,
    output logic [CNT_W-1:0] pos_d_o
);

    typedef struct packed {
        logic [CNT_W-1:0] pos;
    } ctr_t;

    ctr_t ctr_d, ctr_q;

    always_comb begin
        ctr_d = ctr_q;
        if (ctr_q.pos == CNT_W'(FRAME_CYC - 1)) begin
            ctr_d.pos = '0;
        end else begin
            ctr_d.pos = ctr_q.pos + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            ctr_q <= '0;
        end else begin
            ctr_q <= ctr_d;
        end
    end

    // Downstream registers load the decode of this value; under reset it is
    // cycle 0, so their contents match the counter's reset state.
    assign pos_d_o = rst_i ? '0 : ctr_d.pos;
    assign pos_q_o = ctr_q.pos;

endmodule

// File: rtl/rtg_geom.sv
module rtg_geom #(
    parameter int unsigned FIELD_LINES  = 312,
    parameter int unsigned FIRST_LINE   = 31,
    parameter int unsigned FIRST_COL    = 33,
    parameter int unsigned ACTIVE_LINES = 256,
    parameter int unsigned ACTIVE_COLS  = 80,
    parameter int unsigned HS_START     = 8,
    parameter int unsigned HS_END       = 18,
    parameter int unsigned VS_START     = 4,
    parameter int unsigned VS_END       = 7,
    parameter int unsigned H_W          = 7,
    parameter int unsigned L_W          = 10,
    parameter int unsigned CNT_W        = 17
) (
    input  logic             clk_i,
    input  logic [CNT_W-1:0] pos_d_i,
    // decode of the next count, for logic that registers alongside
    output logic [L_W-1:0]   line_d_o,
    output logic [H_W-1:0]   col_d_o,
    output logic             active_d_o,
    output logic             sync_d_o,
    // registered decode, aligned with the counter
    output logic [L_W-1:0]   line_o,
    output logic [H_W-1:0]   col_o,
    output logic             field_o,
    output logic             hsync_o,
    output logic             vsync_o
);

    localparam int unsigned T_W = L_W + 2;

    typedef struct packed {
        logic [L_W-1:0] line;
        logic [H_W-1:0] col;
        logic           field;
        logic           hs;
        logic           vs;
    } geo_t;

    geo_t geo_d, geo_q;

    logic [H_W-1:0] h_raw;
    logic [L_W-1:0] l_raw;
    logic [T_W-1:0] t_sum;
    logic [T_W-1:0] t_rel;
    logic           vs_f1;
    logic           vs_f2;

    always_comb begin
        h_raw = pos_d_i[H_W-1:0];
        l_raw = pos_d_i[CNT_W-1:H_W];

        // Line relative to the first display line, folded into one field.
        t_sum = T_W'(l_raw) + T_W'(FIELD_LINES - FIRST_LINE);
        if (t_sum >= T_W'(2 * FIELD_LINES)) begin
            t_rel = t_sum - T_W'(2 * FIELD_LINES);
        end else if (t_sum >= T_W'(FIELD_LINES)) begin
            t_rel = t_sum - T_W'(FIELD_LINES);
        end else begin
            t_rel = t_sum;
        end

        vs_f1 = (32'(l_raw) >= VS_START) && (32'(l_raw) < VS_END);
        vs_f2 = (32'(l_raw) >= VS_START + FIELD_LINES) &&
                (32'(l_raw) < VS_END + FIELD_LINES);

        geo_d.line  = L_W'(t_rel);
        geo_d.col   = h_raw - H_W'(FIRST_COL);
        geo_d.field = 32'(l_raw) >= FIRST_LINE + FIELD_LINES;
        geo_d.hs    = (32'(h_raw) >= HS_START) && (32'(h_raw) < HS_END);
        geo_d.vs    = vs_f1 || vs_f2;
    end

    always_ff @(posedge clk_i) begin
        geo_q <= geo_d;
    end

    assign line_d_o   = geo_d.line;
    assign col_d_o    = geo_d.col;
    assign active_d_o = (32'(t_rel) < ACTIVE_LINES) && (32'(geo_d.col) < ACTIVE_COLS);
    assign sync_d_o   = geo_d.hs || geo_d.vs;

    assign line_o  = geo_q.line;
    assign col_o   = geo_q.col;
    assign field_o = geo_q.field;
    assign hsync_o = geo_q.hs;
    assign vsync_o = geo_q.vs;

endmodule

// File: rtl/rtg_irq.sv
module rtg_irq #(
    parameter int unsigned         CNT_W = 17,
    parameter int unsigned         N_POS = 2,
    parameter logic [N_POS*32-1:0] POS   = '0
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [CNT_W-1:0] pos_d_i,
    output logic             pulse_o
);

    typedef struct packed {
        logic pulse;
    } irq_t;

    irq_t irq_d, irq_q;
    logic [N_POS-1:0] hit;

    for (genvar gi = 0; gi < N_POS; gi++) begin : g_hit
        assign hit[gi] = (pos_d_i == CNT_W'(POS[gi*32 +: 32]));
    end

    always_comb begin
        irq_d       = irq_q;
        irq_d.pulse = |hit;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            irq_q <= '0;
        end else begin
            irq_q <= irq_d;
        end
    end

    assign pulse_o = irq_q.pulse;

endmodule

// File: rtl/rtg_fetch.sv
module rtg_fetch
    import rtg_pkg::*;
#(
    parameter int unsigned ADDR_W      = 16,
    parameter int unsigned BYTE_W      = 8,
    parameter int unsigned SCREEN_BASE = 16'h3000,
    parameter int unsigned H_W         = 7,
    parameter int unsigned L_W         = 10
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              mode_half_i,
    input  logic              half_gate_i,
    input  logic              sync_i,
    input  logic              active_i,
    input  logic [L_W-1:0]    line_i,
    input  logic [H_W-1:0]    col_i,
    input  logic [BYTE_W-1:0] mem_data_i,
    output logic              mem_rd_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [1:0]        stage_o,
    output logic              pix_vld_o,
    output logic [BYTE_W-1:0] pix_o
);

    typedef struct packed {
        stage_e            stage;
        logic              fetch;
        logic [ADDR_W-1:0] addr;
    } fet_t;

    fet_t fet_d, fet_q;

    always_comb begin
        fet_d = fet_q;

        // Sync outranks blank, blank outranks pixels.
        if (sync_i) begin
            fet_d.stage = STG_SYNC;
        end else if (active_i) begin
            fet_d.stage = STG_PIXEL;
        end else begin
            fet_d.stage = STG_BLANK;
        end

        fet_d.fetch = (fet_d.stage == STG_PIXEL) && (!mode_half_i || half_gate_i);

        // Pointer to the byte of the next fetch: step after each fetch,
        // restart at the top-left cell of every field.
        if (fet_q.fetch) begin
            fet_d.addr = fet_q.addr + 1'b1;
        end
        if ((line_i == '0) && (col_i == '0)) begin
            fet_d.addr = ADDR_W'(SCREEN_BASE);
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            fet_q <= '{stage: STG_BLANK, fetch: 1'b0, addr: ADDR_W'(SCREEN_BASE)};
        end else begin
            fet_q <= fet_d;
        end
    end

    // Bit-reverse so the byte's top bit lands on the leftmost pixel.
    for (genvar gb = 0; gb < BYTE_W; gb++) begin : g_px
        assign pix_o[gb] = fet_q.fetch & mem_data_i[BYTE_W-1-gb];
    end

    assign mem_rd_o   = fet_q.fetch;
    assign mem_addr_o = fet_q.addr;
    assign pix_vld_o  = fet_q.fetch;
    assign stage_o    = fet_q.stage;

endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen #(
    parameter int unsigned LINE_CYC     = 128,
    parameter int unsigned FRAME_LINES  = 625,
    parameter int unsigned FIELD_LINES  = 312,
    parameter int unsigned FIRST_LINE   = 31,
    parameter int unsigned FIRST_COL    = 33,
    parameter int unsigned ACTIVE_LINES = 256,
    parameter int unsigned ACTIVE_COLS  = 80,
    parameter int unsigned HS_START     = 8,
    parameter int unsigned HS_END       = 18,
    parameter int unsigned VS_START     = 4,
    parameter int unsigned VS_END       = 7,
    parameter int unsigned RTC_POS_A    = 16704,
    parameter int unsigned RTC_POS_B    = 56704,
    parameter int unsigned HALF_BIT     = 3,
    parameter int unsigned BYTE_W       = 8,
    parameter int unsigned ADDR_W       = 16,
    parameter int unsigned SCREEN_BASE  = 16'h3000,
    localparam int unsigned H_W         = $clog2(LINE_CYC),
    localparam int unsigned L_W         = $clog2(FRAME_LINES)
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              mode_half_i,
    input  logic [BYTE_W-1:0] mem_data_i,
    output logic              mem_rd_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              hsync_o,
    output logic              vsync_o,
    output logic [1:0]        stage_o,
    output logic              field_o,
    output logic [L_W-1:0]    line_o,
    output logic [H_W-1:0]    col_o,
    output logic              irq_disp_end_o,
    output logic              irq_rtc_o,
    output logic              pix_vld_o,
    output logic [BYTE_W-1:0] pix_o
);

    localparam int unsigned CNT_W     = H_W + L_W;
    localparam int unsigned FRAME_CYC = LINE_CYC * FRAME_LINES;
    localparam int unsigned DE_POS_A  = (FIRST_LINE + ACTIVE_LINES) * LINE_CYC;
    localparam int unsigned DE_POS_B  = (FIRST_LINE + FIELD_LINES + ACTIVE_LINES) * LINE_CYC;

    logic [CNT_W-1:0] pos_q;
    logic [CNT_W-1:0] pos_d;
    logic [L_W-1:0]   line_d;
    logic [H_W-1:0]   col_d;
    logic             active_d;
    logic             sync_d;
    logic             unused_pos_q;

    rtg_frame_ctr #(
        .FRAME_CYC (FRAME_CYC),
        .CNT_W     (CNT_W)
    ) ctr_i (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .pos_q_o (pos_q),
        .pos_d_o (pos_d)
    );

    assign unused_pos_q = ^pos_q;

    rtg_geom #(
        .FIELD_LINES  (FIELD_LINES),
        .FIRST_LINE   (FIRST_LINE),
        .FIRST_COL    (FIRST_COL),
        .ACTIVE_LINES (ACTIVE_LINES),
        .ACTIVE_COLS  (ACTIVE_COLS),
        .HS_START     (HS_START),
        .HS_END       (HS_END),
        .VS_START     (VS_START),
        .VS_END       (VS_END),
        .H_W          (H_W),
        .L_W          (L_W),
        .CNT_W        (CNT_W)
    ) geom_i (
        .clk_i      (clk_i),
        .pos_d_i    (pos_d),
        .line_d_o   (line_d),
        .col_d_o    (col_d),
        .active_d_o (active_d),
        .sync_d_o   (sync_d),
        .line_o     (line_o),
        .col_o      (col_o),
        .field_o    (field_o),
        .hsync_o    (hsync_o),
        .vsync_o    (vsync_o)
    );

    rtg_irq #(
        .CNT_W (CNT_W),
        .N_POS (2),
        .POS   ({32'(DE_POS_B), 32'(DE_POS_A)})
    ) de_irq_i (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .pos_d_i (pos_d),
        .pulse_o (irq_disp_end_o)
    );

    rtg_irq #(
        .CNT_W (CNT_W),
        .N_POS (2),
        .POS   ({32'(RTC_POS_B), 32'(RTC_POS_A)})
    ) rtc_irq_i (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .pos_d_i (pos_d),
        .pulse_o (irq_rtc_o)
    );

    rtg_fetch #(
        .ADDR_W      (ADDR_W),
        .BYTE_W      (BYTE_W),
        .SCREEN_BASE (SCREEN_BASE),
        .H_W         (H_W),
        .L_W         (L_W)
    ) fetch_i (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .mode_half_i (mode_half_i),
        .half_gate_i (pos_d[HALF_BIT]),
        .sync_i      (sync_d),
        .active_i    (active_d),
        .line_i      (line_d),
        .col_i       (col_d),
        .mem_data_i  (mem_data_i),
        .mem_rd_o    (mem_rd_o),
        .mem_addr_o  (mem_addr_o),
        .stage_o     (stage_o),
        .pix_vld_o   (pix_vld_o),
        .pix_o       (pix_o)
    );

endmodule

// File: rtl/raster_timing_gen_chk.sv
module raster_timing_gen_chk #(
    parameter int unsigned H_W    = 7,
    parameter int unsigned ADDR_W = 16
) (
    input logic              clk_i,
    input logic              rst_i,
    input logic              hsync_o,
    input logic              vsync_o,
    input logic [1:0]        stage_o,
    input logic [H_W-1:0]    col_o,
    input logic              irq_disp_end_o,
    input logic              irq_rtc_o,
    input logic              mem_rd_o,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic              pix_vld_o
);

    // R6
    de_pulse_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        irq_disp_end_o |=> !irq_disp_end_o);

    // R7
    rtc_pulse_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        irq_rtc_o |=> !irq_rtc_o);

    // R5
    stage_code_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        stage_o != 2'd3);

    // R4
    sync_wins_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (hsync_o || vsync_o) |-> (stage_o == 2'd0));

    // R11
    pix_in_stage_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        pix_vld_o |-> (stage_o == 2'd2));

    // R3
    col_step_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !$past(rst_i) |-> (col_o == H_W'($past(col_o) + 1'b1)));

    // R11
    addr_step_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (mem_rd_o && $past(mem_rd_o) && !$past(rst_i)) |->
            (mem_addr_o == ADDR_W'($past(mem_addr_o) + 1'b1)));

endmodule

bind raster_timing_gen raster_timing_gen_chk #(
    .H_W    (H_W),
    .ADDR_W (ADDR_W)
) chk_i (
    .clk_i          (clk_i),
    .rst_i          (rst_i),
    .hsync_o        (hsync_o),
    .vsync_o        (vsync_o),
    .stage_o        (stage_o),
    .col_o          (col_o),
    .irq_disp_end_o (irq_disp_end_o),
    .irq_rtc_o      (irq_rtc_o),
    .mem_rd_o       (mem_rd_o),
    .mem_addr_o     (mem_addr_o),
    .pix_vld_o      (pix_vld_o)
);

// File: tb/raster_timing_gen_tb_top.sv
module raster_timing_gen_tb_top;

    localparam int LC    = 128;
    localparam int FLD   = 312;
    localparam int FGL   = 31;
    localparam int FGC   = 33;
    localparam int AL    = 256;
    localparam int AC    = 80;
    localparam int FRAME = 80000;
    localparam logic [15:0] BASE = 16'h3000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mode_half = 1'b0;
    logic [7:0]  mem_data;
    logic        mem_rd;
    logic [15:0] mem_addr;
    logic        hsync, vsync, field, irq_de, irq_rtc, pix_vld;
    logic [1:0]  stage;
    logic [9:0]  line;
    logic [6:0]  col;
    logic [7:0]  pix;

    int checks = 0;
    int errors = 0;

    // 20 ns period at a 1 ns time unit: 50 MHz.
    always #10 clk = ~clk;

    function automatic logic [7:0] mem_model(input logic [15:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h3C;
    endfunction

    function automatic logic [7:0] flip(input logic [7:0] b);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = b[7 - i];
        return r;
    endfunction

    assign mem_data = mem_model(mem_addr);

    raster_timing_gen dut_i (
        .clk_i          (clk),
        .rst_i          (rst),
        .mode_half_i    (mode_half),
        .mem_data_i     (mem_data),
        .mem_rd_o       (mem_rd),
        .mem_addr_o     (mem_addr),
        .hsync_o        (hsync),
        .vsync_o        (vsync),
        .stage_o        (stage),
        .field_o        (field),
        .line_o         (line),
        .col_o          (col),
        .irq_disp_end_o (irq_de),
        .irq_rtc_o      (irq_rtc),
        .pix_vld_o      (pix_vld),
        .pix_o          (pix)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic check_cycle0(input string req, input string tag);
        chk(req, {tag, " line_o"}, int'(line), 281);
        chk(req, {tag, " col_o"}, int'(col), 95);
        chk(req, {tag, " field_o"}, int'(field), 0);
        chk(req, {tag, " stage_o"}, int'(stage), 1);
        chk(req, {tag, " sync"}, int'({hsync, vsync}), 0);
        chk(req, {tag, " irq"}, int'({irq_de, irq_rtc}), 0);
        chk(req, {tag, " fetch"}, int'({mem_rd, pix_vld}), 0);
    endtask

    // R1: state held in reset and just after release.
    task automatic t_reset;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_cycle0("R1", "in reset");
        rst = 1'b0;
        check_cycle0("R1", "after release");
    endtask

    // One full frame from cycle 0, compared cycle by cycle against the
    // requirement formulas. Entered and left at a negedge showing cycle 0.
    task automatic t_frame(input bit half);
        int geo_bad, sync_bad, stg_bad, pix_bad, adr_bad, dark_bad;
        int de_n, rtc_n, de_wrong, rtc_wrong;
        int de_p0, de_p1, rtc_p0, rtc_p1;
        int px0, px1;
        int ln, h, rel, cl, stg, pexp;
        bit fld, act, hs, vs, fe;
        logic [15:0] ea;
        string m;
        geo_bad = 0; sync_bad = 0; stg_bad = 0; pix_bad = 0; adr_bad = 0; dark_bad = 0;
        de_n = 0; rtc_n = 0; de_wrong = 0; rtc_wrong = 0;
        de_p0 = -1; de_p1 = -1; rtc_p0 = -1; rtc_p1 = -1;
        px0 = 0; px1 = 0;
        ea = BASE;
        m = half ? "half" : "wide";
        mode_half = half;
        for (int n = 0; n < FRAME; n++) begin
            ln  = n / LC;
            h   = n % LC;
            rel = (ln + FLD - FGL) % FLD;
            cl  = (h - FGC + LC) % LC;
            fld = (ln >= FGL + FLD);
            act = (rel < AL) && (cl < AC);
            hs  = (h >= 8) && (h < 18);
            vs  = ((ln >= 4) && (ln < 7)) || ((ln >= 316) && (ln < 319));
            stg = (hs || vs) ? 0 : (act ? 2 : 1);
            fe  = (stg == 2) && (!half || ((h & 8) != 0));
            if (rel == 0 && cl == 0) ea = BASE;

            if (int'(line) != rel || int'(col) != cl || field != fld) geo_bad++;
            if (hsync != hs || vsync != vs) sync_bad++;
            if (int'(stage) != stg) stg_bad++;
            if (mem_rd != fe || pix_vld != fe) adr_bad++;
            if (fe) begin
                if (mem_addr != ea) adr_bad++;
                if (pix != flip(mem_model(ea))) pix_bad++;
                if (fld) px1 += 8; else px0 += 8;
                ea = ea + 16'd1;
            end else if (pix != 8'd0) begin
                dark_bad++;
            end

            if (irq_de) begin
                de_n++;
                if (de_p0 < 0) de_p0 = n; else de_p1 = n;
                if (n != 36736 && n != 76672) de_wrong++;
            end
            if (irq_rtc) begin
                rtc_n++;
                if (rtc_p0 < 0) rtc_p0 = n; else rtc_p1 = n;
                if (n != 16704 && n != 56704) rtc_wrong++;
            end
            @(negedge clk);
        end

        chk("R3", {m, " line/col/field mismatches"}, geo_bad, 0);
        chk("R4", {m, " sync mismatches"}, sync_bad, 0);
        chk("R5", {m, " stage mismatches"}, stg_bad, 0);
        chk("R6", {m, " display-end pulses"}, de_n, 2);
        chk("R6", {m, " display-end first cycle"}, de_p0, 36736);
        chk("R6", {m, " display-end second cycle"}, de_p1, 76672);
        chk("R6", {m, " display-end misplaced"}, de_wrong, 0);
        chk("R7", {m, " rtc pulses"}, rtc_n, 2);
        chk("R7", {m, " rtc first cycle"}, rtc_p0, 16704);
        chk("R7", {m, " rtc second cycle"}, rtc_p1, 56704);
        chk("R7", {m, " rtc misplaced"}, rtc_wrong, 0);
        if (half) begin
            chk("R9", "half field 1 pixels", px0, 81920);
            chk("R9", "half field 2 pixels", px1, 81920);
        end else begin
            chk("R8", "wide field 1 pixels", px0, 163840);
            chk("R8", "wide field 2 pixels", px1, 163840);
        end
        chk("R10", {m, " pixel order mismatches"}, pix_bad, 0);
        chk("R10", {m, " non-dark idle pixels"}, dark_bad, 0);
        chk("R11", {m, " fetch/address mismatches"}, adr_bad, 0);
        // R2: after 80000 cycles the decode is back at cycle 0.
        chk("R2", {m, " wrap line_o"}, int'(line), 281);
        chk("R2", {m, " wrap col_o"}, int'(col), 95);
    endtask

    // R1/R7: reset taken mid-frame restarts the counter from cycle 0.
    task automatic t_restart;
        int k;
        repeat (1000) @(negedge clk);
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check_cycle0("R1", "mid-frame reset");
        k = 0;
        while (!irq_rtc && k < 20000) begin
            @(negedge clk);
            k++;
        end
        chk("R7", "rtc cycle after mid-frame reset", k, 16704);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_frame(1'b0);
        t_frame(1'b1);
        t_restart();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule